// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive path of an Ethernet MAC and decides whether an incoming frame is kept, based only on its 48-bit destination address. The destination bytes arrive one per clock on a byte stream that carries start-of-frame and end-of-frame markers. The block builds the address as the bytes arrive and also runs a CRC-32 over them. One cycle after the sixth byte it gives a single verdict: accept or reject, together with the address class.

A frame is kept for any of these reasons. Its address equals the station address. It is a broadcast and broadcasts are allowed. It is a multicast whose hash-table bit is set. Or the filter is in promiscuous mode. The station address, the 64-bit multicast hash table and the mode word come from host-writable registers outside the block. The block samples them on the clock edge that takes in the sixth byte. A frame that ends before its sixth byte is reported as rejected.

Top module: `rx_dest_filter`

## Requirements
- R1: After a synchronous reset, `verdict_valid` and `verdict_accept` are low and `verdict_kind` is 0. A partly received address is discarded by reset, so bytes that follow reset without a start marker give no verdict.
- R2: A verdict is a pulse on `verdict_valid` that lasts one cycle. It is high in the cycle after the clock edge that takes in the sixth destination byte. Each frame gives at most one verdict, and bytes after the sixth give none. `verdict_accept` is never high while `verdict_valid` is low.
- R3: Destination byte k is the k-th byte received, counting the start byte as 0. Station byte 0 is `sta_hi[15:8]` and byte 1 is `sta_hi[7:0]`. Station bytes 2, 3, 4 and 5 are `sta_lo[31:24]`, `sta_lo[23:16]`, `sta_lo[15:8]` and `sta_lo[7:0]`. A unicast address that equals all six station bytes is accepted. Any other unicast address is rejected.
- R4: An all-ones address is a broadcast. It is accepted when `cfg_mode[3]` is 0 and rejected when `cfg_mode[3]` is 1, unless R6 applies.
- R5: An address is multicast when bit 0 of byte 0 is 1 and the address is not all ones. Its hash index is bits 31:26 of a CRC-32 over the six bytes. The CRC starts from 0xFFFFFFFF, takes each byte least significant bit first, uses polynomial 0x04C11DB7, and applies no final inversion. Index i below 32 selects `hash_lo[i]`, and index i of 32 or more selects `hash_hi[i-32]`. The frame is accepted when the selected bit is 1.
- R6: When `cfg_mode[5]` is 1, every frame that reaches its sixth byte is accepted.
- R7: When `in_eof` arrives with between one and five bytes of the frame received, including the byte in that same cycle, the next cycle carries a verdict with `verdict_accept` = 0 and `verdict_kind` = 0. This holds in promiscuous mode too.
- R8: `verdict_kind` encodes the class: 0 means too short, 1 unicast, 2 multicast and 3 broadcast.
- R9: A byte with `in_sof` high starts a new address at byte 0 and discards any partial address.
- R10: Cycles with `in_valid` low do not advance the byte count. A stream with gaps gives the same verdict, one cycle after its sixth valid byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` carries a destination byte this cycle |
| in_sof | input | 1 | This byte is the first byte of a frame |
| in_eof | input | 1 | The frame ends in this cycle |
| in_byte | input | 8 | Received byte |
| cfg_mode | input | 32 | Mode word; bit 3 rejects broadcast, bit 5 is promiscuous |
| sta_lo | input | 32 | Station address bytes 2..5 |
| sta_hi | input | 16 | Station address bytes 0..1 |
| hash_lo | input | 32 | Multicast hash bits for indexes 0..31 |
| hash_hi | input | 32 | Multicast hash bits for indexes 32..63 |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | Frame is kept |
| verdict_kind | output | 2 | Address class of the verdict |

## Verification
A wrong byte count shows up at the ports right away: the verdict strobe comes a cycle early, a cycle late, or twice for one frame. A wrong shift of the captured address turns station matches into rejections and turns broadcasts into unicast kinds, and it does so on the first frame checked. A fault in the running CRC, or in how its top six bits select a hash-table half, can be seen only in multicast verdicts. A sweep over 64 multicast addresses with only one half of the table filled exposes that fault within the first few frames.

// File: rtl/rx_dafilt_pkg.sv
package rx_dafilt_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_BYTES  = 6;
    localparam int ADDR_W      = BYTE_W * ADDR_BYTES;
    localparam int HASH_IDX_W  = 6;
    localparam int MODE_W      = 32;
    localparam int MODE_BC_REJ = 3;
    localparam int MODE_PROMIS = 5;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        DA_SHORT     = 2'd0,
        DA_UNICAST   = 2'd1,
        DA_MULTICAST = 2'd2,
        DA_BROADCAST = 2'd3
    } da_kind_e;

    typedef struct packed {
        logic     accept;
        da_kind_e kind;
    } verdict_t;

    // One byte into a left-shifting CRC-32 state, data bit 0 first.
    function automatic logic [31:0] crc_step(input logic [31:0] cur,
                                             input logic [BYTE_W-1:0] din);
        logic [31:0] st;
        st = cur;
        for (int b = 0; b < BYTE_W; b++) begin
            if (st[31] ^ din[b])
                st = {st[30:0], 1'b0} ^ CRC_POLY;
            else
                st = {st[30:0], 1'b0};
        end
        return st;
    endfunction

endpackage

// File: rtl/dafilt_capture.sv
module dafilt_capture
    import rx_dafilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              take,
    output logic              last_byte,
    output logic              short_end,
    output logic [ADDR_W-1:0] full_da
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0]  cnt_q, cnt_after;
    logic [ADDR_W-1:0] sr_q;

    always_comb begin
        take      = in_valid && (in_sof || (cnt_q != '0 && cnt_q != FULL));
        cnt_after = cnt_q;
        if (take)
            cnt_after = in_sof ? ONE : cnt_q + ONE;
        last_byte = take && (cnt_after == FULL);
        short_end = in_eof && !last_byte && (cnt_after != '0) && (cnt_after != FULL);
        full_da   = {sr_q[ADDR_W-BYTE_W-1:0], in_byte};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else begin
            cnt_q <= in_eof ? '0 : cnt_after;
            if (take)
                sr_q <= in_sof ? {{(ADDR_W-BYTE_W){1'b0}}, in_byte} : full_da;
        end
    end

    // R10: counter never runs past the address length
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

    // R2: once the address is complete, further bytes are not taken
    assert_done_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == FULL && !in_sof && !in_eof) |=> (cnt_q == FULL));

endmodule

// File: rtl/dafilt_crc.sv
module dafilt_crc
    import rx_dafilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              restart,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [31:0]       crc_nx
);
    logic [31:0] crc_q;

    always_comb crc_nx = crc_step(restart ? CRC_SEED : crc_q, in_byte);

    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= CRC_SEED;
        else if (take)
            crc_q <= crc_nx;
    end

endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
    import rx_dafilt_pkg::*;
(
    input  logic [ADDR_W-1:0] da,
    input  logic [31:0]       crc,
    input  logic [MODE_W-1:0] mode,
    input  logic [31:0]       sta_lo,
    input  logic [15:0]       sta_hi,
    input  logic [31:0]       hash_lo,
    input  logic [31:0]       hash_hi,
    output verdict_t          verdict
);
    logic                  is_bc, is_mc, own_hit, hash_hit;
    logic [HASH_IDX_W-1:0] idx;

    always_comb begin
        is_bc    = &da;
        is_mc    = da[ADDR_W-BYTE_W] && !is_bc;
        own_hit  = (da == {sta_hi, sta_lo});
        idx      = crc[31 -: HASH_IDX_W];
        hash_hit = idx[HASH_IDX_W-1] ? hash_hi[idx[HASH_IDX_W-2:0]]
                                     : hash_lo[idx[HASH_IDX_W-2:0]];
        if (is_bc)      verdict.kind = DA_BROADCAST;
        else if (is_mc) verdict.kind = DA_MULTICAST;
        else            verdict.kind = DA_UNICAST;
        verdict.accept = mode[MODE_PROMIS]
                       | (is_bc && !mode[MODE_BC_REJ])
                       | own_hit
                       | (is_mc && hash_hit);
    end

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rx_dafilt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [7:0]  in_byte,
    input  logic [31:0] cfg_mode,
    input  logic [31:0] sta_lo,
    input  logic [15:0] sta_hi,
    input  logic [31:0] hash_lo,
    input  logic [31:0] hash_hi,
    output logic        verdict_valid,
    output logic        verdict_accept,
    output logic [1:0]  verdict_kind
);
    logic              take, last_byte, short_end;
    logic [ADDR_W-1:0] full_da;
    logic [31:0]       crc_nx;
    verdict_t          dec, vq;
    logic              vld_q;

    dafilt_capture u_cap (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_byte(in_byte), .take(take),
        .last_byte(last_byte), .short_end(short_end), .full_da(full_da)
    );

    dafilt_crc u_crc (
        .clk(clk), .rst(rst), .take(take), .restart(in_sof),
        .in_byte(in_byte), .crc_nx(crc_nx)
    );

    dafilt_decide u_dec (
        .da(full_da), .crc(crc_nx), .mode(cfg_mode), .sta_lo(sta_lo),
        .sta_hi(sta_hi), .hash_lo(hash_lo), .hash_hi(hash_hi), .verdict(dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            vq    <= '{accept: 1'b0, kind: DA_SHORT};
        end else begin
            vld_q <= last_byte || short_end;
            if (last_byte)
                vq <= dec;
            else
                vq <= '{accept: 1'b0, kind: DA_SHORT};
        end
    end

    assign verdict_valid  = vld_q;
    assign verdict_accept = vq.accept;
    assign verdict_kind   = vq.kind;

    // R6: promiscuous mode accepts a completed address
    assert_promisc_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (last_byte && cfg_mode[MODE_PROMIS]) |=> (verdict_valid && verdict_accept));

    // R4: broadcast with reject bit and no promiscuous override is dropped
    assert_bcast_reject_R4: assert property (@(posedge clk) disable iff (rst)
        (last_byte && (&full_da) && cfg_mode[MODE_BC_REJ] && !cfg_mode[MODE_PROMIS])
        |=> (verdict_valid && !verdict_accept && verdict_kind == DA_BROADCAST));

    // R7: short frames never pass
    assert_short_reject_R7: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && verdict_kind == DA_SHORT) |-> !verdict_accept);

    // R2: accept only travels with the strobe
    assert_accept_strobed_R2: assert property (@(posedge clk) disable iff (rst)
        verdict_accept |-> verdict_valid);

endmodule

// File: tb/tb_rx_dest_filter.sv
module tb_rx_dest_filter;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sof, in_eof;
    logic [7:0]  in_byte;
    logic [31:0] cfg_mode, sta_lo, hash_lo, hash_hi;
    logic [15:0] sta_hi;
    logic        verdict_valid, verdict_accept;
    logic [1:0]  verdict_kind;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    rx_dest_filter dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_byte(in_byte), .cfg_mode(cfg_mode),
        .sta_lo(sta_lo), .sta_hi(sta_hi), .hash_lo(hash_lo), .hash_hi(hash_hi),
        .verdict_valid(verdict_valid), .verdict_accept(verdict_accept),
        .verdict_kind(verdict_kind)
    );

    // kinds per R8
    localparam logic [1:0] K_SH = 2'd0, K_UC = 2'd1, K_MC = 2'd2, K_BC = 2'd3;

    typedef struct packed {
        logic [47:0] da;
        logic        prom;
        logic        brej;
        logic [1:0]  hsel;  // 0 empty, 1 own bit only, 2 all but own bit, 3 full
        logic        acc;
        logic [1:0]  kind;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{48'h0211_2233_4455, 1'b0, 1'b0, 2'd0, 1'b1, K_UC},  // R3 match
        '{48'h0211_2233_4456, 1'b0, 1'b0, 2'd3, 1'b0, K_UC},  // R3 last byte off
        '{48'h0011_2233_4455, 1'b0, 1'b0, 2'd0, 1'b0, K_UC},  // R3 first byte off
        '{48'h5544_3322_1102, 1'b0, 1'b0, 2'd0, 1'b0, K_MC},  // R3 reversed order
        '{48'h0311_2233_4455, 1'b0, 1'b0, 2'd0, 1'b0, K_MC},  // R5 empty table
        '{48'h0311_2233_4455, 1'b0, 1'b0, 2'd3, 1'b1, K_MC},  // R5 full table
        '{48'h0100_5E00_0001, 1'b0, 1'b0, 2'd2, 1'b0, K_MC},  // R5 own bit clear
        '{48'h0100_5E00_0001, 1'b0, 1'b0, 2'd1, 1'b1, K_MC},  // R5 own bit set
        '{48'h3333_0000_00FB, 1'b0, 1'b0, 2'd1, 1'b1, K_MC},  // R5
        '{48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, 2'd0, 1'b1, K_BC},  // R4 allowed
        '{48'hFFFF_FFFF_FFFF, 1'b0, 1'b1, 2'd3, 1'b0, K_BC},  // R4 rejected
        '{48'hFFFF_FFFF_FFFF, 1'b1, 1'b1, 2'd0, 1'b1, K_BC},  // R6 overrides R4
        '{48'h0A0B_0C0D_0E0F, 1'b1, 1'b0, 2'd0, 1'b1, K_UC},  // R6 stranger
        '{48'h0A0B_0C0D_0E0F, 1'b0, 1'b0, 2'd0, 1'b0, K_UC}   // R3 stranger
    };

    // CRC-32 as R5 defines it, walked over the 48 address bits in wire order
    function automatic logic [5:0] hash_index(input logic [47:0] da);
        logic [31:0] r;
        logic        bitv;
        r = 32'hFFFF_FFFF;
        for (int n = 0; n < 48; n++) begin
            bitv = da[47 - 8*(n/8) - 7 + (n%8)];
            r    = (r[31] ^ bitv) ? ((r << 1) ^ 32'h04C1_1DB7) : (r << 1);
        end
        return r[31:26];
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic e,
                         input logic [7:0] b);
        @(negedge clk);
        in_valid = v; in_sof = s; in_eof = e; in_byte = b;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic set_cfg(input logic prom, input logic brej,
                           input logic [1:0] hsel, input logic [47:0] da);
        logic [63:0] tbl;
        logic [5:0]  ix;
        ix = hash_index(da);
        case (hsel)
            2'd0: tbl = '0;
            2'd1: tbl = 64'd1 << ix;
            2'd2: tbl = ~(64'd1 << ix);
            default: tbl = '1;
        endcase
        cfg_mode = 32'd0;
        cfg_mode[5] = prom;
        cfg_mode[3] = brej;
        hash_lo = tbl[31:0];
        hash_hi = tbl[63:32];
    endtask

    // six bytes, eof on the last; returns sampled verdict one cycle later
    task automatic send_da(input logic [47:0] da, output logic v,
                           output logic a, output logic [1:0] k);
        for (int i = 0; i < 6; i++)
            drive(1'b1, i == 0, i == 5, da[47 - 8*i -: 8]);
        idle();
        v = verdict_valid; a = verdict_accept; k = verdict_kind;
        idle();
        chk(!verdict_valid, "R2", "strobe longer than one cycle", verdict_valid, 0);
    endtask

    logic       sv, sa;
    logic [1:0] sk;
    int         lo_seen, hi_seen;

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 0; in_sof = 0; in_eof = 0; in_byte = 0;
        cfg_mode = 0; hash_lo = 0; hash_hi = 0;
        sta_hi = 16'h0211; sta_lo = 32'h2233_4455;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!verdict_valid && !verdict_accept && verdict_kind == 2'd0, "R1",
            "reset outputs", {verdict_valid, verdict_accept, verdict_kind}, 0);
        rst = 1'b0;
        idle();

        // table walk: R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            set_cfg(VECS[i].prom, VECS[i].brej, VECS[i].hsel, VECS[i].da);
            send_da(VECS[i].da, sv, sa, sk);
            chk(sv, "R2", $sformatf("vec %0d strobe", i), sv, 1);
            chk(sa == VECS[i].acc, "R3/R4/R5/R6", $sformatf("vec %0d accept", i),
                sa, VECS[i].acc);
            chk(sk == VECS[i].kind, "R8", $sformatf("vec %0d kind", i), sk, VECS[i].kind);
        end

        // R5: sweep multicast addresses with only the lower half of the table set
        cfg_mode = 0; hash_lo = '1; hash_hi = '0;
        lo_seen = 0; hi_seen = 0;
        for (int k = 0; k < 64; k++) begin
            logic [47:0] da;
            logic        expa;
            da   = {40'h01_005E_0000, 8'(k)};
            expa = (hash_index(da) < 6'd32);
            if (expa) lo_seen++; else hi_seen++;
            send_da(da, sv, sa, sk);
            chk(sv && sa == expa, "R5", $sformatf("sweep %0d half select", k),
                {sv, sa}, {1'b1, expa});
        end
        chk(lo_seen > 0 && hi_seen > 0, "R5", "sweep covered both halves",
            lo_seen, hi_seen);

        // R7: short frame, even in promiscuous mode
        cfg_mode = 32'h20;
        drive(1'b1, 1'b1, 1'b0, 8'h02);
        drive(1'b1, 1'b0, 1'b0, 8'h11);
        drive(1'b1, 1'b0, 1'b1, 8'h22);
        idle();
        chk(verdict_valid && !verdict_accept && verdict_kind == K_SH, "R7",
            "short frame verdict", {verdict_valid, verdict_accept, verdict_kind},
            {1'b1, 1'b0, K_SH});
        idle();
        chk(!verdict_valid, "R7", "short verdict length", verdict_valid, 0);

        // R7: one-byte frame with sof and eof together
        drive(1'b1, 1'b1, 1'b1, 8'hFF);
        idle();
        chk(verdict_valid && !verdict_accept && verdict_kind == K_SH, "R7",
            "single-byte frame", {verdict_valid, verdict_accept, verdict_kind},
            {1'b1, 1'b0, K_SH});
        idle();

        // R2: trailing payload gives no second verdict
        cfg_mode = 0;
        for (int i = 0; i < 6; i++)
            drive(1'b1, i == 0, 1'b0, 8'hFF);
        for (int i = 0; i < 5; i++) begin
            drive(1'b1, 1'b0, i == 4, 8'hFF);
            if (i == 0)
                chk(verdict_valid && verdict_accept, "R2", "verdict after byte six",
                    {verdict_valid, verdict_accept}, 2'b11);
            else
                chk(!verdict_valid, "R2", "no verdict on payload", verdict_valid, 0);
        end
        idle();
        chk(!verdict_valid, "R2", "no verdict at payload end", verdict_valid, 0);
        idle();

        // R10: gaps between bytes
        for (int i = 0; i < 6; i++) begin
            drive(1'b1, i == 0, i == 5, {sta_hi, sta_lo}[47 - 8*i -: 8]);
            if (i != 5) begin
                idle();
                idle();
                chk(!verdict_valid, "R10", "no early verdict in gap", verdict_valid, 0);
            end
        end
        idle();
        chk(verdict_valid && verdict_accept && verdict_kind == K_UC, "R10",
            "verdict after gapped stream", {verdict_valid, verdict_accept, verdict_kind},
            {1'b1, 1'b1, K_UC});
        idle();

        // R9: restart mid-address
        drive(1'b1, 1'b1, 1'b0, 8'h0A);
        drive(1'b1, 1'b0, 1'b0, 8'h0B);
        drive(1'b1, 1'b0, 1'b0, 8'h0C);
        send_da({sta_hi, sta_lo}, sv, sa, sk);
        chk(sv && sa && sk == K_UC, "R9", "restart then station match",
            {sv, sa, sk}, {1'b1, 1'b1, K_UC});

        // R1: reset discards a partial address
        drive(1'b1, 1'b1, 1'b0, 8'h02);
        drive(1'b1, 1'b0, 1'b0, 8'h11);
        drive(1'b1, 1'b0, 1'b0, 8'h22);
        @(negedge clk); in_valid = 0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        drive(1'b1, 1'b0, 1'b0, 8'h33);
        drive(1'b1, 1'b0, 1'b0, 8'h44);
        drive(1'b1, 1'b0, 1'b1, 8'h55);
        idle();
        chk(!verdict_valid, "R1", "no verdict after reset mid-address", verdict_valid, 0);
        idle();
        chk(!verdict_valid && !verdict_accept, "R1", "quiet after reset",
            {verdict_valid, verdict_accept}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule